// File: doc/BRIEF.md
# Receive Polarity Auto-Correction

This block sits behind the twisted-pair receive front end of a multiport repeater. For each port it works out whether the pair is wired with its polarity swapped, and if so it raises an invert control that the data path applies to every later packet on that port. The front end reports polarity as single-cycle strobes. A negative end-of-transmit delimiter or a negative link pulse is evidence of reversal. The positive forms show the wiring is correct. The first strobe after the port becomes ready to decide fixes the decision. That decision is then held until a link-fail indication or a reset opens a new decision window.

Each port runs its own small state machine with four states. `ST_OFF` means correction is disabled. `ST_HUNT` means the port is enabled and waiting for the first polarity strobe. `ST_NORM` means the port is locked as not inverted. `ST_INV` means the port is locked as inverted. The named transitions are:

- strap-load: reset puts every port in `ST_HUNT` or `ST_OFF`, following the strap level on the last reset cycle.
- disable: a control write with enable low moves a port from any state to `ST_OFF`.
- enable: a control write with enable high moves a port from `ST_OFF` to `ST_HUNT`.
- lock-inverted: a negative strobe moves a port from `ST_HUNT` to `ST_INV`.
- lock-normal: a positive strobe moves a port from `ST_HUNT` to `ST_NORM`.
- relink: a link-fail indication moves a port from `ST_NORM` or `ST_INV` back to `ST_HUNT`.

Every other input combination leaves the state unchanged.

Top module: `rx_polarity_fix`

## Requirements
- R1: While `rst` is high, `locked_o` and `invert_o` are 0 on every port. After release, `en_o` on every port equals the level `strap_i` had on the last clock edge with `rst` high, and `locked_o` and `invert_o` stay 0.
- R2: In state `ST_HUNT` with no control write and no link-fail, a negative strobe makes `invert_o`=1 and `locked_o`=1 one cycle later.
- R3: In state `ST_HUNT` with no control write, no link-fail and no negative strobe, a positive strobe makes `locked_o`=1 and `invert_o`=0 one cycle later.
- R4: When a negative and a positive strobe arrive on the same cycle in `ST_HUNT`, the negative one wins and the port locks inverted.
- R5: Once a port is locked, polarity strobes of either sign change neither `invert_o` nor `locked_o`.
- R6: `link_fail_i` high on a locked port returns it to `ST_HUNT` (`locked_o`=0, `invert_o`=0) one cycle later. Strobes that arrive together with link-fail are dropped. Once link-fail is low, the next strobe decides again.
- R7: A control write (`ctl_we_i`=1) with `ctl_en_i`=0 puts the port in `ST_OFF` from any state: `en_o`, `locked_o` and `invert_o` are all 0. While in `ST_OFF`, strobes and link-fail have no effect.
- R8: A control write with `ctl_en_i`=1 moves the port from `ST_OFF` to `ST_HUNT` (`en_o`=1, `locked_o`=0). On an already enabled port the same write changes nothing, and any lock is kept.
- R9: A control write takes priority over link-fail and over both strobes on the same cycle and port. Those other inputs are dropped for that cycle.
- R10: Ports are independent. Inputs for one port never change the outputs of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strap_i | input | 1 | Default enable level, captured while in reset |
| ctl_we_i | input | N_PORTS | Per-port control write strobe |
| ctl_en_i | input | N_PORTS | Per-port enable value used with `ctl_we_i` |
| link_fail_i | input | N_PORTS | Per-port link-fail indication |
| neg_evt_i | input | N_PORTS | Negative delimiter or negative link pulse strobe |
| pos_evt_i | input | N_PORTS | Positive delimiter or positive link pulse strobe |
| en_o | output | N_PORTS | Port has correction enabled |
| locked_o | output | N_PORTS | Polarity decision taken and held |
| invert_o | output | N_PORTS | Invert the received data |

## Verification
Every result is due exactly one clock after the edge that samples its inputs. The state register is the only register in the path, and the outputs are decoded from it without further registering. The bench drives inputs just after a falling edge, lets one rising edge pass, and compares all ports at the following falling edge. Each of the 32 input combinations is applied from each of the four states on each port, and a per-port model in the bench advances at the same cadence. The strap result is compared on the first falling edge after reset release.

// File: rtl/rxpol_pkg.sv
package rxpol_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HUNT = 2'd1,
        ST_NORM = 2'd2,
        ST_INV  = 2'd3
    } pol_state_e;

    typedef enum logic [2:0] {
        EV_NONE  = 3'd0,
        EV_DIS   = 3'd1,
        EV_ENA   = 3'd2,
        EV_LFAIL = 3'd3,
        EV_NEG   = 3'd4,
        EV_POS   = 3'd5
    } pol_evt_e;

endpackage

// File: rtl/rxpol_evt_arb.sv
// Reduces the per-port inputs of one cycle to a single event, by priority:
// control write, then link-fail, then negative strobe, then positive strobe.
module rxpol_evt_arb
    import rxpol_pkg::*;
(
    input  logic     ctl_we,
    input  logic     ctl_en,
    input  logic     link_fail,
    input  logic     neg_evt,
    input  logic     pos_evt,
    output pol_evt_e evt
);

    always_comb begin
        if (ctl_we) begin
            evt = ctl_en ? EV_ENA : EV_DIS;
        end else if (link_fail) begin
            evt = EV_LFAIL;
        end else if (neg_evt) begin
            evt = EV_NEG;
        end else if (pos_evt) begin
            evt = EV_POS;
        end else begin
            evt = EV_NONE;
        end
    end

endmodule

// File: rtl/rxpol_port_fsm.sv
// Per-port decision state machine: state register, next-state logic, output decode.
module rxpol_port_fsm
    import rxpol_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     strap,
    input  pol_evt_e evt,
    output logic     en_o,
    output logic     locked_o,
    output logic     invert_o
);

    pol_state_e state_q;
    pol_state_e state_d;

    // State register; while in reset the strap level selects the start state
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= strap ? ST_HUNT : ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (evt == EV_ENA) state_d = ST_HUNT;
            end
            ST_HUNT: begin
                case (evt)
                    EV_DIS:  state_d = ST_OFF;
                    EV_NEG:  state_d = ST_INV;
                    EV_POS:  state_d = ST_NORM;
                    default: state_d = ST_HUNT;
                endcase
            end
            ST_NORM, ST_INV: begin
                case (evt)
                    EV_DIS:   state_d = ST_OFF;
                    EV_LFAIL: state_d = ST_HUNT;
                    default:  state_d = state_q;
                endcase
            end
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        en_o     = 1'b1;
        locked_o = 1'b0;
        invert_o = 1'b0;
        unique case (state_q)
            ST_OFF:  en_o = 1'b0;
            ST_HUNT: ;
            ST_NORM: locked_o = 1'b1;
            ST_INV: begin
                locked_o = 1'b1;
                invert_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/rx_polarity_fix.sv
module rx_polarity_fix
    import rxpol_pkg::*;
#(
    parameter int N_PORTS = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               strap_i,
    input  logic [N_PORTS-1:0] ctl_we_i,
    input  logic [N_PORTS-1:0] ctl_en_i,
    input  logic [N_PORTS-1:0] link_fail_i,
    input  logic [N_PORTS-1:0] neg_evt_i,
    input  logic [N_PORTS-1:0] pos_evt_i,
    output logic [N_PORTS-1:0] en_o,
    output logic [N_PORTS-1:0] locked_o,
    output logic [N_PORTS-1:0] invert_o
);

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        pol_evt_e evt;

        rxpol_evt_arb u_arb (
            .ctl_we    (ctl_we_i[p]),
            .ctl_en    (ctl_en_i[p]),
            .link_fail (link_fail_i[p]),
            .neg_evt   (neg_evt_i[p]),
            .pos_evt   (pos_evt_i[p]),
            .evt       (evt)
        );

        rxpol_port_fsm u_fsm (
            .clk      (clk),
            .rst      (rst),
            .strap    (strap_i),
            .evt      (evt),
            .en_o     (en_o[p]),
            .locked_o (locked_o[p]),
            .invert_o (invert_o[p])
        );
    end

endmodule

// File: rtl/rxpol_chk.sv
module rxpol_chk #(
    parameter int N_PORTS = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [N_PORTS-1:0] ctl_we_i,
    input logic [N_PORTS-1:0] ctl_en_i,
    input logic [N_PORTS-1:0] link_fail_i,
    input logic [N_PORTS-1:0] neg_evt_i,
    input logic [N_PORTS-1:0] pos_evt_i,
    input logic [N_PORTS-1:0] en_o,
    input logic [N_PORTS-1:0] locked_o,
    input logic [N_PORTS-1:0] invert_o
);

    for (genvar i = 0; i < N_PORTS; i++) begin : g_chk
        p_neg_locks_r2: assert property (@(posedge clk) disable iff (rst)
            (en_o[i] && !locked_o[i] && !ctl_we_i[i] && !link_fail_i[i] && neg_evt_i[i])
            |=> (invert_o[i] && locked_o[i]));

        p_pos_locks_r3: assert property (@(posedge clk) disable iff (rst)
            (en_o[i] && !locked_o[i] && !ctl_we_i[i] && !link_fail_i[i] && !neg_evt_i[i] && pos_evt_i[i])
            |=> (locked_o[i] && !invert_o[i]));

        p_lock_held_r5: assert property (@(posedge clk) disable iff (rst)
            (locked_o[i] && !ctl_we_i[i] && !link_fail_i[i])
            |=> (locked_o[i] && $stable(invert_o[i])));

        p_relink_r6: assert property (@(posedge clk) disable iff (rst)
            (locked_o[i] && !ctl_we_i[i] && link_fail_i[i])
            |=> (en_o[i] && !locked_o[i] && !invert_o[i]));

        p_disable_r7: assert property (@(posedge clk) disable iff (rst)
            (ctl_we_i[i] && !ctl_en_i[i])
            |=> (!en_o[i] && !locked_o[i] && !invert_o[i]));

        p_off_ignores_r7: assert property (@(posedge clk) disable iff (rst)
            (!en_o[i] && !ctl_we_i[i])
            |=> (!en_o[i] && !locked_o[i]));

        p_enable_r8: assert property (@(posedge clk) disable iff (rst)
            (!en_o[i] && ctl_we_i[i] && ctl_en_i[i])
            |=> (en_o[i] && !locked_o[i]));
    end

endmodule

bind rx_polarity_fix rxpol_chk #(.N_PORTS(N_PORTS)) u_rxpol_chk (
    .clk         (clk),
    .rst         (rst),
    .ctl_we_i    (ctl_we_i),
    .ctl_en_i    (ctl_en_i),
    .link_fail_i (link_fail_i),
    .neg_evt_i   (neg_evt_i),
    .pos_evt_i   (pos_evt_i),
    .en_o        (en_o),
    .locked_o    (locked_o),
    .invert_o    (invert_o)
);

// File: tb/rx_polarity_fix_tb.sv
module rx_polarity_fix_tb;

    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          strap;
    logic [NP-1:0] we, en, lf, ng, ps;
    logic [NP-1:0] en_o, lk_o, inv_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;
    int mst[NP];   // model state: 0 off, 1 hunt, 2 locked normal, 3 locked inverted

    always #5 clk = ~clk;

    rx_polarity_fix #(.N_PORTS(NP)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .strap_i     (strap),
        .ctl_we_i    (we),
        .ctl_en_i    (en),
        .link_fail_i (lf),
        .neg_evt_i   (ng),
        .pos_evt_i   (ps),
        .en_o        (en_o),
        .locked_o    (lk_o),
        .invert_o    (inv_o)
    );

    function automatic int nxt(int s, bit w, bit e, bit l, bit n, bit p);
        if (w) return e ? ((s == 0) ? 1 : s) : 0;     // R7 R8 R9
        if (s == 0) return 0;                          // R7
        if (l) return 1;                               // R6
        if (s >= 2) return s;                          // R5
        if (n) return 3;                               // R2 R4
        if (p) return 2;                               // R3
        return 1;
    endfunction

    function automatic string tag(int s, bit w, bit e, bit l, bit n, bit p);
        if (w) return (l | n | p) ? "R9" : (e ? "R8" : "R7");
        if (s == 0) return "R7";
        if (l) return "R6";
        if (s >= 2) return "R5";
        if (n && p) return "R4";
        if (p && !n) return "R3";
        return "R2";
    endfunction

    task automatic chk(string t, string what, int q, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s port %0d %s actual=%b expected=%b", t, q, what, act, exp);
        end
    endtask

    task automatic check_all(string t, int p);
        for (int q = 0; q < NP; q++) begin
            string tq;
            tq = (p < 0 || q == p) ? t : "R10";
            chk(tq, "en_o",     q, en_o[q],  mst[q] != 0);
            chk(tq, "locked_o", q, lk_o[q],  mst[q] >= 2);
            chk(tq, "invert_o", q, inv_o[q], mst[q] == 3);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic apply(int p, bit w, bit e, bit l, bit n, bit pp);
        string t;
        t = tag(mst[p], w, e, l, n, pp);
        we[p] = w; en[p] = e; lf[p] = l; ng[p] = n; ps[p] = pp;
        step();
        we = '0; en = '0; lf = '0; ng = '0; ps = '0;
        mst[p] = nxt(mst[p], w, e, l, n, pp);
        check_all(t, p);
    endtask

    task automatic do_reset(bit early, bit last);
        rst = 1'b1;
        strap = early;
        step();
        step();
        // R1: no lock or inversion while reset is held
        for (int q = 0; q < NP; q++) begin
            chk("R1", "locked_o in reset", q, lk_o[q], 1'b0);
            chk("R1", "invert_o in reset", q, inv_o[q], 1'b0);
        end
        strap = last;
        step();
        rst = 1'b0;
        strap = ~last;
        for (int q = 0; q < NP; q++) mst[q] = last ? 1 : 0;
        check_all("R1", -1);
        step();
        check_all("R1", -1);
    endtask

    task automatic go_state(int p, int s);
        apply(p, 1, 0, 0, 0, 0);
        if (s > 0) apply(p, 1, 1, 0, 0, 0);
        if (s == 2) apply(p, 0, 0, 0, 0, 1);
        if (s == 3) apply(p, 0, 0, 0, 1, 0);
    endtask

    initial begin
        rst = 1'b1; strap = 1'b0;
        we = '0; en = '0; lf = '0; ng = '0; ps = '0;
        do_reset(1'b0, 1'b1);   // R1: strap high on last reset cycle
        do_reset(1'b1, 1'b0);   // R1: strap low on last reset cycle
        do_reset(1'b0, 1'b1);

        // R6: relock after link-fail, then decide again on the opposite polarity
        apply(0, 0, 0, 0, 1, 0);
        apply(0, 0, 0, 1, 0, 1);
        apply(0, 0, 0, 0, 0, 1);

        // Sweep: every state, every input combination, every port
        for (int p = 0; p < NP; p++) begin
            for (int s = 0; s < 4; s++) begin
                for (int c = 0; c < 32; c++) begin
                    go_state(p, s);
                    apply(p, c[4], c[3], c[2], c[1], c[0]);
                end
            end
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: all requirements actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule